// File: doc/BRIEF.md
# Operand Addressing Unit

This unit turns the two 6-bit operand selectors of a 16-bit instruction into operand descriptors that an execute stage can use directly. Each descriptor says whether the operand is a general register, a memory word, a special register (stack pointer, program counter or overflow) or a constant. It carries the register index, the effective address, the special-register id or the constant value, together with a flag that says whether a result may be stored to it. The unit owns the program counter and the stack pointer. It fetches extra instruction words through the program counter when a selector needs one. It moves the stack pointer for pop and push, using a full-descending stack.

Operation is started with a one-cycle `start_i` pulse while the unit is idle. Operand A is resolved first and operand B second. When both are done, `done_o` pulses for one cycle. At that point the descriptors and the extra-cycle charge for the pair are valid, and they stay valid until the next start. A skip input marks an instruction that will not execute. Its memory-access charges are then dropped, but its extra words and stack movements still take place. Loads of the program counter and the stack pointer come from the surrounding core and are accepted only while the unit is idle.

Top module: `opnd_addr_unit`

## Requirements
- R1: Selectors 0x00–0x07 give kind GPR (code 0) with value equal to the register index, and add no extra cycle.
- R2: Selectors 0x08–0x0F give kind MEM (code 1) with the address taken from register (sel & 7), and add 1 cycle.
- R3: Selectors 0x10–0x17 fetch one word at PC and advance PC. They give kind MEM with address (word + register[sel & 7]) mod 2^16, and add 2 cycles.
- R4: Selector 0x18 gives MEM at SP and then increments SP. Selector 0x19 gives MEM at SP and leaves SP unchanged. Selector 0x1A decrements SP and gives MEM at the new SP. SP wraps modulo 2^16 in both directions, and each of these selectors adds 1 cycle.
- R5: Selectors 0x1B, 0x1C and 0x1D give kind SPR (code 2) with values 0 (SP), 1 (PC) and 2 (overflow), and add no cycle.
- R6: Selector 0x1E fetches a word and gives MEM at that word, adding 2 cycles. Selector 0x1F fetches a word and gives kind LIT (code 3) with that word as value, adding 1 cycle.
- R7: Selectors 0x20–0x3F give kind LIT with value sel − 0x20 and add no cycle. The writable flag is low for every LIT result and high for every other kind.
- R8: With skip set, the one-cycle memory-access charge is dropped. Word fetches are still charged 1 cycle each and still advance PC, and stack selectors still move SP.
- R9: Operand A is resolved before operand B, so B sees the PC and SP left by A.
- R10: A word request holds with a stable address until it is acknowledged, and PC advances by exactly one for each acknowledged word.
- R11: After reset PC equals RESET_PC, SP equals RESET_SP, and no request or done is active.
- R12: PC and SP loads take effect in the cycle after they are presented while idle. Loads presented while busy are ignored.
- R13: `done_o` is a one-cycle pulse, and `extra_cyc_o` then equals the sum of both operands' charges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin resolving a selector pair (honoured when idle) |
| sel_a_i | input | 6 | Operand A selector |
| sel_b_i | input | 6 | Operand B selector |
| skip_i | input | 1 | Instruction will be skipped |
| gpr_i | input | 128 | General registers, register k at bits 16k+15:16k |
| pc_load_i | input | 1 | Load PC (idle only) |
| pc_load_val_i | input | 16 | PC load value |
| sp_load_i | input | 1 | Load SP (idle only) |
| sp_load_val_i | input | 16 | SP load value |
| word_req_o | output | 1 | Extra instruction word request |
| word_addr_o | output | 16 | Address of requested word (current PC) |
| word_vld_i | input | 1 | Requested word is present |
| word_i | input | 16 | Requested word |
| busy_o | output | 1 | Resolution in progress |
| done_o | output | 1 | Both operands resolved (one cycle) |
| a_kind_o | output | 2 | Operand A kind: 0 GPR, 1 MEM, 2 SPR, 3 LIT |
| a_val_o | output | 16 | Operand A index, address, id or value |
| a_wr_o | output | 1 | Operand A may be written |
| b_kind_o | output | 2 | Operand B kind |
| b_val_o | output | 16 | Operand B index, address, id or value |
| b_wr_o | output | 1 | Operand B may be written |
| extra_cyc_o | output | 3 | Extra cycles charged for the pair |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |

## Verification
Two kinds of side effect can fall on the same instruction. One is the PC advance of a word-fetching selector and the other is the SP movement of a stack selector. Both can also hit the same pointer twice in a row, when A and B both push, both pop or both fetch words. The bench provokes these cases with directed pairs placed at the wrap points (SP at 0 and 0xFFFE, PC at 0xFFFF) and with random selector pairs whose word acknowledges arrive after random delays. It judges them by comparing each descriptor and the final PC and SP against a model that applies A's effects strictly before B's.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  localparam int SEL_W = 6;

  typedef enum logic [1:0] {
    K_GPR = 2'd0,
    K_MEM = 2'd1,
    K_SPR = 2'd2,
    K_LIT = 2'd3
  } kind_e;

  typedef enum logic [3:0] {
    C_GPR, C_IND, C_IDX, C_POP, C_PEEK, C_PUSH, C_SPR, C_NWIND, C_NWLIT, C_SLIT
  } cls_e;

  typedef enum logic [1:0] {
    SP_HOLD = 2'd0,
    SP_INC  = 2'd1,
    SP_DEC  = 2'd2
  } sp_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPA  = 2'd1,
    ST_OPB  = 2'd2,
    ST_FIN  = 2'd3
  } st_e;
endpackage

// File: rtl/opnd_decode.sv
module opnd_decode
  import opnd_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  output cls_e             cls_o,
  output logic             needs_word_o
);
  always_comb begin
    cls_o = C_SLIT;
    if (!sel_i[5]) begin
      unique case (sel_i[4:3])
        2'd0: cls_o = C_GPR;
        2'd1: cls_o = C_IND;
        2'd2: cls_o = C_IDX;
        default: begin
          unique case (sel_i[2:0])
            3'd0:    cls_o = C_POP;
            3'd1:    cls_o = C_PEEK;
            3'd2:    cls_o = C_PUSH;
            3'd6:    cls_o = C_NWIND;
            3'd7:    cls_o = C_NWLIT;
            default: cls_o = C_SPR;
          endcase
        end
      endcase
    end
  end

  assign needs_word_o = (cls_o == C_IDX) || (cls_o == C_NWIND) || (cls_o == C_NWLIT);
endmodule

// File: rtl/opnd_resolve.sv
module opnd_resolve
  import opnd_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NGPR = 8
) (
  input  cls_e             cls_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [NGPR*DW-1:0] gpr_i,
  input  logic [DW-1:0]    word_i,
  input  logic [DW-1:0]    sp_i,
  input  logic             skip_i,
  output kind_e            kind_o,
  output logic [DW-1:0]    val_o,
  output logic [1:0]       cost_o,
  output sp_op_e           sp_op_o
);
  localparam int IW = $clog2(NGPR);

  logic [IW-1:0] ridx;
  logic [DW-1:0] rval;
  logic [1:0]    mem_cost;

  assign ridx     = sel_i[IW-1:0];
  assign rval     = gpr_i[ridx*DW +: DW];
  assign mem_cost = skip_i ? 2'd0 : 2'd1;  // access charge dropped on skip

  always_comb begin
    kind_o  = K_LIT;
    val_o   = '0;
    cost_o  = 2'd0;
    sp_op_o = SP_HOLD;
    unique case (cls_i)
      C_GPR: begin
        kind_o = K_GPR;
        val_o  = DW'(ridx);
      end
      C_IND: begin
        kind_o = K_MEM;
        val_o  = rval;
        cost_o = mem_cost;
      end
      C_IDX: begin
        kind_o = K_MEM;
        val_o  = word_i + rval;
        cost_o = 2'd1 + mem_cost;
      end
      C_POP: begin
        kind_o  = K_MEM;
        val_o   = sp_i;
        cost_o  = mem_cost;
        sp_op_o = SP_INC;
      end
      C_PEEK: begin
        kind_o = K_MEM;
        val_o  = sp_i;
        cost_o = mem_cost;
      end
      C_PUSH: begin
        kind_o  = K_MEM;
        val_o   = sp_i - DW'(1);
        cost_o  = mem_cost;
        sp_op_o = SP_DEC;
      end
      C_SPR: begin
        kind_o = K_SPR;
        val_o  = DW'(3'(sel_i[2:0] - 3'd3));
      end
      C_NWIND: begin
        kind_o = K_MEM;
        val_o  = word_i;
        cost_o = 2'd1 + mem_cost;
      end
      C_NWLIT: begin
        kind_o = K_LIT;
        val_o  = word_i;
        cost_o = 2'd1;
      end
      default: begin
        kind_o = K_LIT;
        val_o  = DW'(sel_i[4:0]);
      end
    endcase
  end
endmodule

// File: rtl/opnd_ptr.sv
module opnd_ptr #(
  parameter int          DW  = 16,
  parameter int unsigned RST = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= DW'(RST);
    else if (load_i) q_o <= load_val_i;
    else if (inc_i)  q_o <= q_o + DW'(1);
    else if (dec_i)  q_o <= q_o - DW'(1);
  end
endmodule

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit
  import opnd_pkg::*;
#(
  parameter int          DW       = 16,
  parameter int          NGPR     = 8,
  parameter int unsigned RESET_PC = 0,
  parameter int unsigned RESET_SP = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [SEL_W-1:0]   sel_a_i,
  input  logic [SEL_W-1:0]   sel_b_i,
  input  logic               skip_i,
  input  logic [NGPR*DW-1:0] gpr_i,
  input  logic               pc_load_i,
  input  logic [DW-1:0]      pc_load_val_i,
  input  logic               sp_load_i,
  input  logic [DW-1:0]      sp_load_val_i,
  output logic               word_req_o,
  output logic [DW-1:0]      word_addr_o,
  input  logic               word_vld_i,
  input  logic [DW-1:0]      word_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [1:0]         a_kind_o,
  output logic [DW-1:0]      a_val_o,
  output logic               a_wr_o,
  output logic [1:0]         b_kind_o,
  output logic [DW-1:0]      b_val_o,
  output logic               b_wr_o,
  output logic [2:0]         extra_cyc_o,
  output logic [DW-1:0]      pc_o,
  output logic [DW-1:0]      sp_o
);
  localparam int XW = 3;

  st_e               st_q, st_d;
  logic [SEL_W-1:0]  sel_a_q, sel_b_q, cur_sel;
  logic              skip_q;
  logic [NGPR*DW-1:0] gpr_q;
  kind_e             a_kind_q, b_kind_q, cur_kind;
  logic [DW-1:0]     a_val_q, b_val_q, cur_val;
  logic [XW-1:0]     extra_q;
  cls_e              cur_cls;
  logic              needs_word, in_op, step, idle, start;
  logic [1:0]        cur_cost;
  sp_op_e            cur_sp_op;

  assign idle    = (st_q == ST_IDLE);
  assign in_op   = (st_q == ST_OPA) || (st_q == ST_OPB);
  assign start   = idle && start_i;
  assign cur_sel = (st_q == ST_OPB) ? sel_b_q : sel_a_q;
  assign step    = in_op && (!needs_word || word_vld_i);

  opnd_decode u_dec (
    .sel_i        (cur_sel),
    .cls_o        (cur_cls),
    .needs_word_o (needs_word)
  );

  opnd_resolve #(.DW(DW), .NGPR(NGPR)) u_res (
    .cls_i   (cur_cls),
    .sel_i   (cur_sel),
    .gpr_i   (gpr_q),
    .word_i  (word_i),
    .sp_i    (sp_o),
    .skip_i  (skip_q),
    .kind_o  (cur_kind),
    .val_o   (cur_val),
    .cost_o  (cur_cost),
    .sp_op_o (cur_sp_op)
  );

  opnd_ptr #(.DW(DW), .RST(RESET_PC)) u_pc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (idle && pc_load_i),
    .load_val_i (pc_load_val_i),
    .inc_i      (step && needs_word),
    .dec_i      (1'b0),
    .q_o        (pc_o)
  );

  opnd_ptr #(.DW(DW), .RST(RESET_SP)) u_sp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (idle && sp_load_i),
    .load_val_i (sp_load_val_i),
    .inc_i      (step && cur_sp_op == SP_INC),
    .dec_i      (step && cur_sp_op == SP_DEC),
    .q_o        (sp_o)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_OPA;
      ST_OPA:  if (step)    st_d = ST_OPB;
      ST_OPB:  if (step)    st_d = ST_FIN;
      default:              st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      sel_a_q  <= '0;
      sel_b_q  <= '0;
      skip_q   <= 1'b0;
      gpr_q    <= '0;
      a_kind_q <= K_GPR;
      b_kind_q <= K_GPR;
      a_val_q  <= '0;
      b_val_q  <= '0;
      extra_q  <= '0;
    end else begin
      st_q <= st_d;
      if (start) begin
        sel_a_q <= sel_a_i;
        sel_b_q <= sel_b_i;
        skip_q  <= skip_i;
        gpr_q   <= gpr_i;
        extra_q <= '0;
      end
      if (step) begin
        extra_q <= extra_q + XW'(cur_cost);
        if (st_q == ST_OPA) begin
          a_kind_q <= cur_kind;
          a_val_q  <= cur_val;
        end else begin
          b_kind_q <= cur_kind;
          b_val_q  <= cur_val;
        end
      end
    end
  end

  assign word_req_o  = in_op && needs_word;
  assign word_addr_o = pc_o;
  assign busy_o      = !idle;
  assign done_o      = (st_q == ST_FIN);
  assign a_kind_o    = a_kind_q;
  assign a_val_o     = a_val_q;
  assign a_wr_o      = (a_kind_q != K_LIT);
  assign b_kind_o    = b_kind_q;
  assign b_val_o     = b_val_q;
  assign b_wr_o      = (b_kind_q != K_LIT);
  assign extra_cyc_o = extra_q;
endmodule

// File: rtl/opnd_addr_unit_chk.sv
module opnd_addr_unit_chk #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          word_req_o,
  input logic [DW-1:0] word_addr_o,
  input logic          word_vld_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [2:0]    extra_cyc_o,
  input logic [DW-1:0] pc_o,
  input logic [DW-1:0] sp_o
);
  assert_word_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_req_o && !word_vld_i |=> word_req_o && $stable(word_addr_o));

  assert_pc_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_req_o && word_vld_i |=> pc_o == $past(pc_o) + DW'(1));

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !word_req_o && !done_o);

  assert_sp_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (sp_o == $past(sp_o)) || (sp_o == $past(sp_o) + DW'(1))
               || (sp_o == $past(sp_o) - DW'(1)));

  assert_pc_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !word_req_o |=> $stable(pc_o));

  assert_done_pulse_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_cost_max_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> extra_cyc_o <= 3'd4);
endmodule

bind opnd_addr_unit opnd_addr_unit_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .word_req_o  (word_req_o),
  .word_addr_o (word_addr_o),
  .word_vld_i  (word_vld_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .extra_cyc_o (extra_cyc_o),
  .pc_o        (pc_o),
  .sp_o        (sp_o)
);

// File: tb/opnd_addr_unit_test.sv
module opnd_addr_unit_test;
  localparam int DW = 16;
  localparam int NG = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [5:0] sel_a_i = '0, sel_b_i = '0;
  logic skip_i = 1'b0;
  logic [NG*DW-1:0] gpr_i = '0;
  logic pc_load_i = 1'b0, sp_load_i = 1'b0;
  logic [DW-1:0] pc_load_val_i = '0, sp_load_val_i = '0;
  logic word_req_o, word_vld_i = 1'b0;
  logic [DW-1:0] word_addr_o, word_i = '0;
  logic busy_o, done_o, a_wr_o, b_wr_o;
  logic [1:0] a_kind_o, b_kind_o;
  logic [DW-1:0] a_val_o, b_val_o, pc_o, sp_o;
  logic [2:0] extra_cyc_o;

  int checks = 0, errors = 0, cycles = 0;
  logic [DW-1:0] m_pc, m_sp;

  always #10 clk_i = ~clk_i;  // 50 MHz

  opnd_addr_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .sel_a_i(sel_a_i), .sel_b_i(sel_b_i),
    .skip_i(skip_i), .gpr_i(gpr_i), .pc_load_i(pc_load_i), .pc_load_val_i(pc_load_val_i),
    .sp_load_i(sp_load_i), .sp_load_val_i(sp_load_val_i), .word_req_o(word_req_o),
    .word_addr_o(word_addr_o), .word_vld_i(word_vld_i), .word_i(word_i), .busy_o(busy_o),
    .done_o(done_o), .a_kind_o(a_kind_o), .a_val_o(a_val_o), .a_wr_o(a_wr_o),
    .b_kind_o(b_kind_o), .b_val_o(b_val_o), .b_wr_o(b_wr_o), .extra_cyc_o(extra_cyc_o),
    .pc_o(pc_o), .sp_o(sp_o)
  );

  function automatic logic [DW-1:0] mem_word(input logic [DW-1:0] a);
    return (a * 16'h9E37) ^ 16'h1234;
  endfunction

  // memory responder with random delay
  always @(negedge clk_i) begin
    word_vld_i = word_req_o && (($urandom % 4) != 0);
    word_i     = mem_word(word_addr_o);
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [5:0] s);
    if (s >= 6'h20) return "R7";
    if (s < 6'h08)  return "R1";
    if (s < 6'h10)  return "R2";
    if (s < 6'h18)  return "R3";
    if (s <= 6'h1A) return "R4";
    if (s <= 6'h1D) return "R5";
    return "R6";
  endfunction

  task automatic model_op(input logic [5:0] s, input bit skip, input logic [NG*DW-1:0] g,
                          inout int cost, output logic [1:0] kind, output logic [DW-1:0] val);
    logic [DW-1:0] rv, w;
    int mc;
    rv = g[s[2:0]*DW +: DW];
    mc = skip ? 0 : 1;
    kind = 2'd3; val = '0;
    if (s >= 6'h20) begin kind = 2'd3; val = DW'(s - 6'h20); end
    else if (s < 6'h08) begin kind = 2'd0; val = DW'(s); end
    else if (s < 6'h10) begin kind = 2'd1; val = rv; cost += mc; end
    else if (s < 6'h18) begin
      w = mem_word(m_pc); m_pc = m_pc + 1'b1;
      kind = 2'd1; val = w + rv; cost += 1 + mc;
    end else begin
      case (s)
        6'h18: begin kind = 2'd1; val = m_sp; m_sp = m_sp + 1'b1; cost += mc; end
        6'h19: begin kind = 2'd1; val = m_sp; cost += mc; end
        6'h1A: begin m_sp = m_sp - 1'b1; kind = 2'd1; val = m_sp; cost += mc; end
        6'h1B, 6'h1C, 6'h1D: begin kind = 2'd2; val = DW'(s - 6'h1B); end
        6'h1E: begin w = mem_word(m_pc); m_pc = m_pc + 1'b1; kind = 2'd1; val = w; cost += 1 + mc; end
        default: begin w = mem_word(m_pc); m_pc = m_pc + 1'b1; kind = 2'd3; val = w; cost += 1; end
      endcase
    end
  endtask

  task automatic do_load(input logic [DW-1:0] pcv, input logic [DW-1:0] spv);
    @(negedge clk_i);
    pc_load_i = 1'b1; pc_load_val_i = pcv;
    sp_load_i = 1'b1; sp_load_val_i = spv;
    @(negedge clk_i);
    pc_load_i = 1'b0; sp_load_i = 1'b0;
    m_pc = pcv; m_sp = spv;
    check(pc_o == pcv, "R12", pc_o, pcv);
    check(sp_o == spv, "R12", sp_o, spv);
  endtask

  // busy_load: pulse loads once while busy; they must leave PC/SP untouched
  task automatic run(input logic [5:0] sa, input logic [5:0] sb, input bit skip,
                     input logic [NG*DW-1:0] g, input bit busy_load);
    int cost = 0, w = 0;
    logic [1:0] ka, kb;
    logic [DW-1:0] va, vb;
    model_op(sa, skip, g, cost, ka, va);  // A strictly before B (R9)
    model_op(sb, skip, g, cost, kb, vb);
    @(negedge clk_i);
    start_i = 1'b1; sel_a_i = sa; sel_b_i = sb; skip_i = skip; gpr_i = g;
    @(negedge clk_i);
    start_i = 1'b0;
    if (busy_load) begin
      pc_load_i = 1'b1; pc_load_val_i = 16'hAAAA;
      sp_load_i = 1'b1; sp_load_val_i = 16'h5555;
    end
    while (!done_o && w < 200) begin
      @(negedge clk_i);
      pc_load_i = 1'b0; sp_load_i = 1'b0;
      w++;
    end
    check(done_o, "R13", {31'd0, done_o}, 32'd1);
    check({a_kind_o, a_val_o} == {ka, va}, tag_of(sa), {a_kind_o, a_val_o}, {ka, va});
    check({b_kind_o, b_val_o} == {kb, vb}, tag_of(sb), {b_kind_o, b_val_o}, {kb, vb});
    check(a_wr_o == (ka != 2'd3) && b_wr_o == (kb != 2'd3), "R7", {a_wr_o, b_wr_o}, {ka != 2'd3, kb != 2'd3});
    check(extra_cyc_o == 3'(cost), skip ? "R8" : "R13", extra_cyc_o, cost);
    check(pc_o == m_pc, busy_load ? "R12" : "R10", pc_o, m_pc);
    check(sp_o == m_sp, busy_load ? "R12" : "R9", sp_o, m_sp);
    @(negedge clk_i);
    check(!done_o, "R13", {31'd0, done_o}, 32'd0);
  endtask

  function automatic logic [NG*DW-1:0] rnd_gpr();
    logic [NG*DW-1:0] g;
    for (int i = 0; i < NG; i++) g[i*DW +: DW] = DW'($urandom);
    return g;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    m_pc = '0; m_sp = '0;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    check(pc_o == 16'h0, "R11", pc_o, 0);
    check(sp_o == 16'h0, "R11", sp_o, 0);
    check(!done_o && !busy_o, "R11", {done_o, busy_o}, 0);
    check(!word_req_o, "R11", word_req_o, 0);
    rst_ni = 1'b1;

    // R1/R7/R5 simple
    run(6'h03, 6'h25, 1'b0, rnd_gpr(), 1'b0);
    run(6'h1B, 6'h1D, 1'b0, rnd_gpr(), 1'b0);
    run(6'h1C, 6'h3F, 1'b0, rnd_gpr(), 1'b0);
    // R4/R9 double push across zero, then double pop across top
    do_load(16'h0100, 16'h0000);
    run(6'h1A, 6'h1A, 1'b0, rnd_gpr(), 1'b0);
    do_load(16'h0100, 16'hFFFE);
    run(6'h18, 6'h18, 1'b0, rnd_gpr(), 1'b0);
    run(6'h19, 6'h1A, 1'b0, rnd_gpr(), 1'b0);
    // R3/R9/R10 two word fetches across PC wrap
    do_load(16'hFFFF, 16'h8000);
    run(6'h12, 6'h17, 1'b0, rnd_gpr(), 1'b0);
    // R6 next-word modes
    run(6'h1E, 6'h1F, 1'b0, rnd_gpr(), 1'b0);
    // R2/R8 skip drops access charge, keeps word and stack effects
    run(6'h0A, 6'h1E, 1'b1, rnd_gpr(), 1'b0);
    run(6'h18, 6'h11, 1'b1, rnd_gpr(), 1'b0);
    // R12 loads while busy are ignored
    run(6'h1F, 6'h1A, 1'b0, rnd_gpr(), 1'b1);

    for (int n = 0; n < 400; n++)
      run(6'($urandom), 6'($urandom), (($urandom % 4) == 0), rnd_gpr(), (($urandom % 16) == 0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule